// File: doc/BRIEF.md
# Non-Power-of-Two ROM Address Folder

This block maps any byte address in a large cartridge address window onto a ROM whose byte count need not be a power of two. A caller presents an address together with the ROM size. The block then repeatedly removes the highest set bit of the working address until the address lies below the working size. Each time the removed chunk is smaller than the remaining size, that chunk is taken off the size and credited to a running base. The folded physical offset is the running base plus whatever address is left.

As a result, an image of 12 Mbit seen through a 32 MiB window repeats every 2 MiB. Each repeat holds the low 8 Mbit, then the high 4 Mbit, then the high 4 Mbit again. Simple masking cannot produce this layout. For power-of-two sizes the fold reduces to ordinary wraparound.

Requests enter on a valid/ready channel. The block accepts a request only when `req_ready` is high, and `req_ready` is high exactly when the unit is idle. Results leave on a valid/ready channel. `rsp_valid` and `rsp_offset` stay fixed until the consumer raises `rsp_ready`, so a slow consumer stalls the unit and it takes no new request. The unit handles one fold step per clock.

Top module: `rom_addr_folder`

## Requirements
- R1: After reset, `req_ready` is 1, `busy` is 0 and `rsp_valid` is 0.
- R2: A request with ROM size 0 returns offset 0 for every address.
- R3: A request whose address is already below a nonzero size returns the address unchanged. `rsp_valid` rises on the first clock edge after the accepting edge.
- R4: For a nonzero size, the offset comes from the fold procedure:
  - While the working address is at or above the working size, clear its highest set bit m.
  - If the working size is strictly greater than m, subtract m from the size and add m to the base.
  - When the address drops below the size, the offset is base plus address.
- R5: When the size is a power of two 2^k, the offset equals the address ANDed with 2^k−1.
- R6: With size 0x180000 (12 Mbit), take o = address mod 0x200000. The offset is o when o < 0x100000, and otherwise 0x100000 + (o mod 0x80000).
- R7: Let s be the number of bit removals the R4 procedure performs. `rsp_valid` rises on the (1+s)-th clock edge after the accepting edge, and s never exceeds ADDR_W.
- R8: `busy` is high and `req_ready` is low from the edge after acceptance until the response is taken. A request offered during that time is not accepted and does not change the pending result.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_offset` holds its value. On the edge where both are high, the response is consumed, and `rsp_valid` is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | ADDR_W (28) | Byte address to fold |
| req_size | input | ADDR_W (28) | ROM size in bytes |
| busy | output | 1 | A request is in flight or its response is pending |
| rsp_valid | output | 1 | Folded offset available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_offset | output | ADDR_W (28) | Folded physical byte offset |

## Verification
For every request, the bench first computes the number of bit removals s the fold needs. It then expects `rsp_valid` exactly 1+s rising edges after the accepting edge, which gives one edge for an address already in range and one more for each removal. Inputs change and outputs are read on falling edges, and the bench counts those falling edges from the acceptance to the first sight of `rsp_valid`. Because of this the measured latency does not depend on event order at the rising edge. The hold and ignore checks compare the outputs on every falling edge of the stalled or busy interval against the value first seen.

// File: rtl/addr_fold_pkg.sv
package addr_fold_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RUN  = 2'd1,
    FS_DONE = 2'd2
  } fold_state_e;
endpackage

// File: rtl/afold_msb.sv
// Isolates the highest set bit of a vector as a one-hot value (zero in, zero out).
module afold_msb #(
  parameter int W = 28
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] onehot
);
  // above[i] is set when any bit at position i or higher is set
  logic [W:0] above;
  assign above[W] = 1'b0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_scan
    assign above[i]  = above[i+1] | val[i];
    assign onehot[i] = val[i] & ~above[i+1];
  end
endmodule

// File: rtl/afold_step.sv
// One fold iteration: decides completion and computes the next working state.
module afold_step #(
  parameter int W = 28
) (
  input  logic [W-1:0] cur_addr,
  input  logic [W-1:0] cur_size,
  input  logic [W-1:0] cur_base,
  output logic         finished,
  output logic [W-1:0] fold_out,
  output logic [W-1:0] nxt_addr,
  output logic [W-1:0] nxt_size,
  output logic [W-1:0] nxt_base
);
  logic [W-1:0] top_bit;
  logic         size_zero;
  logic         in_range;
  logic         chunk_fits;

  afold_msb #(.W(W)) u_msb (
    .val    (cur_addr),
    .onehot (top_bit)
  );

  assign size_zero  = (cur_size == '0);
  assign in_range   = (cur_addr < cur_size);
  assign finished   = size_zero | in_range;
  assign fold_out   = size_zero ? '0 : (cur_base + cur_addr);

  assign chunk_fits = (cur_size > top_bit);
  assign nxt_addr   = cur_addr ^ top_bit;
  assign nxt_size   = chunk_fits ? (cur_size - top_bit) : cur_size;
  assign nxt_base   = chunk_fits ? (cur_base + top_bit) : cur_base;
endmodule

// File: rtl/afold_ctrl.sv
// Sequencer: idle -> run (one fold step per clock) -> done (hold until taken).
module afold_ctrl
  import addr_fold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic finished,
  input  logic rsp_ready,
  output logic req_ready,
  output logic busy,
  output logic rsp_valid,
  output logic load_en,
  output logic step_en,
  output logic cap_en
);
  fold_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FS_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    step_en = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (req_valid) begin
          load_en = 1'b1;
          state_d = FS_RUN;
        end
      end
      FS_RUN: begin
        if (finished) begin
          cap_en  = 1'b1;
          state_d = FS_DONE;
        end else begin
          step_en = 1'b1;
        end
      end
      FS_DONE: begin
        if (rsp_ready) state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  assign req_ready = (state_q == FS_IDLE);
  assign busy      = (state_q != FS_IDLE);
  assign rsp_valid = (state_q == FS_DONE);
endmodule

// File: rtl/rom_addr_folder.sv
module rom_addr_folder #(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_size,
  output logic              busy,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_offset
);
  logic [ADDR_W-1:0] work_addr, work_size, work_base, result_q;
  logic [ADDR_W-1:0] nxt_addr, nxt_size, nxt_base, fold_out;
  logic              finished, load_en, step_en, cap_en;

  afold_step #(.W(ADDR_W)) u_step (
    .cur_addr (work_addr),
    .cur_size (work_size),
    .cur_base (work_base),
    .finished (finished),
    .fold_out (fold_out),
    .nxt_addr (nxt_addr),
    .nxt_size (nxt_size),
    .nxt_base (nxt_base)
  );

  afold_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .finished  (finished),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .load_en   (load_en),
    .step_en   (step_en),
    .cap_en    (cap_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_addr <= '0;
      work_size <= '0;
      work_base <= '0;
    end else if (load_en) begin
      work_addr <= req_addr;
      work_size <= req_size;
      work_base <= '0;
    end else if (step_en) begin
      work_addr <= nxt_addr;
      work_size <= nxt_size;
      work_base <= nxt_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (cap_en) result_q <= fold_out;
  end

  assign rsp_offset = result_q;
endmodule

// File: rtl/afold_checker.sv
module afold_checker #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] req_size,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_offset
);
  localparam int RUN_MAX = ADDR_W + 1;
  localparam int CW      = $clog2(RUN_MAX + 2) + 1;

  logic [ADDR_W-1:0] cap_addr, cap_size;
  logic [CW-1:0]     run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_size <= '0;
    end else if (req_valid && req_ready) begin
      cap_addr <= req_addr;
      cap_size <= req_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_cnt <= '0;
    else if (busy && !rsp_valid) run_cnt <= run_cnt + 1'b1;
    else                        run_cnt <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> req_ready && !rsp_valid); // R1
  AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && (cap_size == '0) |-> rsp_offset == '0); // R2
  AST_IN_RANGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && (cap_addr < cap_size) |-> rsp_offset == cap_addr); // R3
  AST_FOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && (cap_size != '0) |-> rsp_offset < cap_size); // R4
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(RUN_MAX)); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_offset)); // R9
  AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> !rsp_valid); // R9
endmodule

bind rom_addr_folder afold_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_offset (rsp_offset)
);

// File: tb/tb_rom_addr_folder.sv
module tb_rom_addr_folder;
  localparam int AW = 28;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [AW-1:0] req_size = '0;
  logic          busy;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [AW-1:0] rsp_offset;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_addr_folder #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_offset(rsp_offset)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected fold from the R4 definition, counting bit removals
  task automatic ref_fold(input logic [AW-1:0] a, input logic [AW-1:0] s,
                          output logic [AW-1:0] r, output int steps);
    logic [AW-1:0] lo, sz, acc, top;
    steps = 0;
    r = '0;
    if (s != '0) begin
      lo = a; sz = s; acc = '0;
      while (lo >= sz) begin
        top = '0;
        for (int b = AW - 1; b >= 0; b--) begin
          if (lo[b]) begin top[b] = 1'b1; break; end
        end
        lo = lo - top;
        if (sz > top) begin
          sz  = sz - top;
          acc = acc + top;
        end
        steps++;
      end
      r = acc + lo;
    end
  endtask

  task automatic run_req(input logic [AW-1:0] a, input logic [AW-1:0] s,
                         input string tag, output logic [AW-1:0] got);
    logic [AW-1:0] exp;
    int exp_steps;
    int lat;
    ref_fold(a, s, exp, exp_steps);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 80) begin @(negedge clk); lat++; end
    got = rsp_offset;
    check(tag, "offset", 64'(rsp_offset), 64'(exp));
    check("R7", "latency", 64'(lat - 1), 64'(1 + exp_steps));
    @(negedge clk);
  endtask

  initial begin
    logic [AW-1:0] got, exp1, a, s, o, want;
    int st;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "req_ready", 64'(req_ready), 64'd1);
    check("R1", "busy", 64'(busy), 64'd0);
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);

    // Exhaustive sweep of small address/size pairs (R2, R3, R4, R7)
    for (int si = 0; si < 64; si++) begin
      for (int ai = 0; ai < 64; ai++) begin
        s = AW'(si); a = AW'(ai);
        run_req(a, s, (si == 0) ? "R2" : ((ai < si) ? "R3" : "R4"), got);
      end
    end

    // R2: zero size with large addresses
    run_req(28'hFFFFFFF, '0, "R2", got);
    run_req(28'h1234567, '0, "R2", got);

    // R4: worst-case removal counts on the full bus
    run_req(28'hFFFFFFF, 28'd1, "R4", got);
    run_req(28'hFFFFFFF, 28'h8000001, "R4", got);
    run_req(28'h8000000, 28'h8000000, "R4", got);

    // R6: 12 Mbit image across a 32 MiB window
    for (int k = 0; k < 128; k++) begin
      a = AW'(k * 32'h40000 + 32'h123 + (k % 5) * 32'h1000);
      s = 28'h180000;
      run_req(a, s, "R4", got);
      o = a % 28'h200000;
      want = (o < 28'h100000) ? o : (28'h100000 + (o % 28'h80000));
      check("R6", "mirror", 64'(got), 64'(want));
    end

    // R5: power-of-two sizes match plain masking
    for (int n = 0; n < 280; n++) begin
      s = '0;
      s[n % AW] = 1'b1;
      a = AW'($urandom);
      run_req(a, s, "R4", got);
      check("R5", "pow2 mask", 64'(got), 64'(a & (s - 1'b1)));
    end

    // R8: requests offered while busy are ignored
    ref_fold(28'h0FFFFFF, 28'd3, exp1, st);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = 28'h0FFFFFF; req_size = 28'd3;
    @(negedge clk);
    check("R8", "busy after accept", 64'(busy), 64'd1);
    check("R8", "ready while busy", 64'(req_ready), 64'd0);
    req_addr = 28'd5; req_size = 28'd7;
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    check("R8", "pending result", 64'(rsp_offset), 64'(exp1));
    @(negedge clk);
    check("R8", "no stray accept", 64'(rsp_valid), 64'd0);
    check("R8", "idle again", 64'(req_ready), 64'd1);

    // R9: response held under back-pressure
    ref_fold(28'd100, 28'd7, exp1, st);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 28'd100; req_size = 28'd7;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got = rsp_offset;
    check("R9", "stalled result", 64'(got), 64'(exp1));
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check("R9", "valid held", 64'(rsp_valid), 64'd1);
      check("R9", "offset held", 64'(rsp_offset), 64'(got));
      check("R9", "not ready", 64'(req_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9", "valid released", 64'(rsp_valid), 64'd0);

    finish_run();
  end
endmodule